// File: doc/BRIEF.md
# Size-Typed Integer ALU

This block is a 64-bit integer execution unit in which every operation runs at a width and signedness chosen per request. Each request carries two 64-bit operands, a 3-bit operation code, a 2-bit size selector and a sign flag. The 64-bit result always represents the sized value exactly. Bits above the chosen width are a copy of the sized sign bit for signed requests and zero for unsigned ones. No bits from a full-width computation remain above the chosen width, so no separate extend or mask instructions are needed after an operation.

Both operands are first reduced to the chosen width and extended with the same rule used for sized loads. The operation is applied, and the raw result is reduced and extended again. Compare produces three flags taken only from the sized operand bits. One register stage holds the result, and a valid bit travels with it.

Top module: `szalu_top`

## Requirements
- R1: A signed request (in_signed=1) of size code 00=8, 01=16, 10=32 or 11=64 bits returns a non-compare result whose bits above the size all equal the sized result's top bit. Example: a signed 8-bit result of 0x80 reads as 0xFFFF_FFFF_FFFF_FF80.
- R2: An unsigned request (in_signed=0) returns a non-compare result whose bits above the size are all zero.
- R3: Opcode 000 (add) and 001 (subtract) wrap modulo 2 to the power of the selected size.
- R4: Opcodes 010, 011 and 100 return the AND, OR and XOR of the sized operands.
- R5: Opcode 101 (shift left) shifts the sized first operand left. The shift amount is the second operand masked to log2 of the size in bits, so a shift of 9 at 8 bits moves by 1.
- R6: Opcode 110 (shift right) is arithmetic when signed and logical when unsigned. It acts on the first operand after that operand has been reduced and extended to the size, and it uses the masked amount from R5.
- R7: Opcode 111 (compare) returns bit0 = equal, bit1 = less-than and bit2 = greater-than, judged at the selected size and signedness. Exactly one of these flags is set, and bits 63:3 are zero.
- R8: Operand bits above the selected size have no effect on any result.
- R9: out_valid is high in the cycle after a cycle with in_valid high, and low after a cycle with in_valid low. out_result changes only on an accepted request.
- R10: Synchronous active-high reset clears out_valid and out_result to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present this cycle |
| in_op | input | 3 | Operation code |
| in_size | input | 2 | Data size code |
| in_signed | input | 1 | 1 = signed, 0 = unsigned |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Second operand / shift amount |
| out_valid | output | 1 | Result valid |
| out_result | output | 64 | Sized, extended result or compare flags |

## Verification
The result depends on no state other than the output register, so any logic fault appears in out_result one cycle after the request that exposes it. A wrong extension lane, a shift mask built from the wrong size, or a comparator that reads unsized operands shows up on the first request whose operands carry differing upper garbage. Random operands carry that garbage on almost every request. Directed cases place sign bits exactly at each size boundary. A fault in the valid path shows up one cycle after in_valid rises or falls.

// File: rtl/szalu_pkg.sv
`timescale 1ns/1ps
package szalu_pkg;
    localparam int XLEN  = 64;
    localparam int NSIZE = 4;
    localparam int SH_W  = $clog2(XLEN);

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4,
        OP_SHL = 3'd5,
        OP_SHR = 3'd6,
        OP_CMP = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        SZ_8  = 2'd0,
        SZ_16 = 2'd1,
        SZ_32 = 2'd2,
        SZ_64 = 2'd3
    } size_e;

    typedef struct packed {
        alu_op_e          op;
        size_e            size;
        logic             sgn;
        logic [XLEN-1:0]  a;
        logic [XLEN-1:0]  b;
    } alu_req_t;

    typedef struct packed {
        logic gt;
        logic lt;
        logic eq;
    } cmp_flags_t;

    function automatic int unsigned size_bits(size_e s);
        return 32'd8 << s;
    endfunction

    function automatic logic [SH_W-1:0] shamt_mask(size_e s);
        return SH_W'(size_bits(s) - 1);
    endfunction

    // Mask-based extension, kept apart from the lane datapath for checking.
    function automatic logic [XLEN-1:0] fit(logic [XLEN-1:0] v, size_e s, logic sgn);
        logic [XLEN-1:0] mask;
        logic            top;
        int unsigned     nb;
        nb = size_bits(s);
        if (nb >= XLEN) return v;
        mask = (XLEN'(1) << nb) - XLEN'(1);
        top  = v[nb-1];
        return (v & mask) | ((sgn && top) ? ~mask : '0);
    endfunction

    function automatic logic is_fitted(logic [XLEN-1:0] v, size_e s, logic sgn);
        return v == fit(v, s, sgn);
    endfunction
endpackage

// File: rtl/szalu_norm.sv
`timescale 1ns/1ps
module szalu_norm
    import szalu_pkg::*;
(
    input  logic [XLEN-1:0] value,
    input  size_e           size,
    input  logic            sgn,
    output logic [XLEN-1:0] fitted
);
    logic [XLEN-1:0] lane [NSIZE];

    for (genvar i = 0; i < NSIZE; i++) begin : g_lane
        localparam int LW = 8 << i;
        if (LW >= XLEN) begin : g_full
            assign lane[i] = value;
        end else begin : g_part
            assign lane[i] = {{(XLEN-LW){sgn & value[LW-1]}}, value[LW-1:0]};
        end
    end

    assign fitted = lane[size];
endmodule

// File: rtl/szalu_core.sv
`timescale 1ns/1ps
module szalu_core
    import szalu_pkg::*;
(
    input  alu_op_e         op,
    input  size_e           size,
    input  logic            sgn,
    input  logic [XLEN-1:0] na,
    input  logic [XLEN-1:0] nb,
    output logic [XLEN-1:0] raw
);
    logic [SH_W-1:0] sh;

    always_comb begin
        sh = nb[SH_W-1:0] & shamt_mask(size);
        unique case (op)
            OP_ADD:  raw = na + nb;
            OP_SUB:  raw = na - nb;
            OP_AND:  raw = na & nb;
            OP_OR:   raw = na | nb;
            OP_XOR:  raw = na ^ nb;
            OP_SHL:  raw = na << sh;
            OP_SHR:  raw = sgn ? XLEN'($signed(na) >>> sh) : (na >> sh);
            default: raw = '0;
        endcase
    end
endmodule

// File: rtl/szalu_cmp.sv
`timescale 1ns/1ps
module szalu_cmp
    import szalu_pkg::*;
(
    input  logic            sgn,
    input  logic [XLEN-1:0] na,
    input  logic [XLEN-1:0] nb,
    output cmp_flags_t      flags
);
    always_comb begin
        flags.eq = (na == nb);
        flags.lt = sgn ? ($signed(na) < $signed(nb)) : (na < nb);
        flags.gt = !flags.eq && !flags.lt;
    end
endmodule

// File: rtl/szalu_top.sv
`timescale 1ns/1ps
module szalu_top
    import szalu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [2:0]  in_op,
    input  logic [1:0]  in_size,
    input  logic        in_signed,
    input  logic [63:0] in_a,
    input  logic [63:0] in_b,
    output logic        out_valid,
    output logic [63:0] out_result
);
    alu_req_t        req;
    logic [XLEN-1:0] na, nb, raw, raw_fit, next_res;
    cmp_flags_t      flags;

    assign req.op   = alu_op_e'(in_op);
    assign req.size = size_e'(in_size);
    assign req.sgn  = in_signed;
    assign req.a    = in_a;
    assign req.b    = in_b;

    szalu_norm u_norm_a (.value(req.a), .size(req.size), .sgn(req.sgn), .fitted(na));
    szalu_norm u_norm_b (.value(req.b), .size(req.size), .sgn(req.sgn), .fitted(nb));

    szalu_core u_core (
        .op(req.op), .size(req.size), .sgn(req.sgn),
        .na(na), .nb(nb), .raw(raw)
    );

    szalu_norm u_norm_r (.value(raw), .size(req.size), .sgn(req.sgn), .fitted(raw_fit));

    szalu_cmp u_cmp (.sgn(req.sgn), .na(na), .nb(nb), .flags(flags));

    assign next_res = (req.op == OP_CMP) ? {{(XLEN-3){1'b0}}, flags} : raw_fit;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_result <= next_res;
        end
    end

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && out_result == '0));

    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && in_valid) |=> out_valid);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && !in_valid) |=> (!out_valid && $stable(out_result)));

    // R1
    signed_ext_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && in_valid && in_op != 3'd7 && in_signed)
        |=> is_fitted(out_result, size_e'($past(in_size)), 1'b1));

    // R2
    unsigned_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && in_valid && in_op != 3'd7 && !in_signed)
        |=> is_fitted(out_result, size_e'($past(in_size)), 1'b0));

    // R7
    cmp_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && in_valid && in_op == 3'd7)
        |=> ($countones(out_result[2:0]) == 1 && out_result[63:3] == '0));
endmodule

// File: tb/tb_szalu_top.sv
`timescale 1ns/1ps
module tb_szalu_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [2:0]  in_op;
    logic [1:0]  in_size;
    logic        in_signed;
    logic [63:0] in_a, in_b;
    logic        out_valid;
    logic [63:0] out_result;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    szalu_top dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_size(in_size), .in_signed(in_signed), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_result(out_result)
    );

    function automatic logic [63:0] ref_fit(logic [63:0] v, logic [1:0] s, logic sg);
        case (s)
            2'd0:    return sg ? {{56{v[7]}},  v[7:0]}  : {56'd0, v[7:0]};
            2'd1:    return sg ? {{48{v[15]}}, v[15:0]} : {48'd0, v[15:0]};
            2'd2:    return sg ? {{32{v[31]}}, v[31:0]} : {32'd0, v[31:0]};
            default: return v;
        endcase
    endfunction

    function automatic logic [63:0] ref_model(logic [2:0] op, logic [1:0] s, logic sg,
                                              logic [63:0] a, logic [63:0] b);
        logic [63:0] fa, fb, r;
        logic signed [63:0] sa;
        int unsigned sh;
        fa = ref_fit(a, s, sg);
        fb = ref_fit(b, s, sg);
        sh = int'(b[5:0]) % (8 << s);
        sa = fa;
        case (op)
            3'd0: r = fa + fb;
            3'd1: r = fa - fb;
            3'd2: r = fa & fb;
            3'd3: r = fa | fb;
            3'd4: r = fa ^ fb;
            3'd5: r = fa << sh;
            3'd6: r = sg ? 64'(sa >>> sh) : (fa >> sh);
            default: begin
                if (fa == fb) return 64'd1;
                if (sg ? ($signed(fa) < $signed(fb)) : (fa < fb)) return 64'd2;
                return 64'd4;
            end
        endcase
        return ref_fit(r, s, sg);
    endfunction

    function automatic string op_tag(logic [2:0] op);
        case (op)
            3'd0, 3'd1:       return "R3";
            3'd2, 3'd3, 3'd4: return "R4";
            3'd5:             return "R5";
            3'd6:             return "R6";
            default:          return "R7";
        endcase
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply one request at a negedge; check at the next negedge (one register).
    task automatic run_op(string tag, logic [2:0] op, logic [1:0] s, logic sg,
                          logic [63:0] a, logic [63:0] b);
        in_valid = 1'b1; in_op = op; in_size = s; in_signed = sg; in_a = a; in_b = b;
        @(negedge clk);
        check({tag, " valid"}, {63'd0, out_valid}, 64'd1);
        check(tag, out_result, ref_model(op, s, sg, a, b));
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] held;
        void'($urandom(32'd20251003));
        rst = 1'b1; in_valid = 1'b0; in_op = '0; in_size = '0; in_signed = 1'b0;
        in_a = '0; in_b = '0;
        @(negedge clk); @(negedge clk);
        // R10: reset state
        check("R10 out_valid", {63'd0, out_valid}, 64'd0);
        check("R10 out_result", out_result, 64'd0);
        rst = 1'b0;
        @(negedge clk);

        // R1 / R3: signed byte overflow to 0x80
        run_op("R1 signed byte add", 3'd0, 2'd0, 1'b1, 64'hDEAD_BEEF_0000_007F, 64'h1234_0000_0000_0001);
        check("R1 literal", out_result, 64'hFFFF_FFFF_FFFF_FF80);
        // R2 / R3: unsigned byte wrap with upper garbage
        run_op("R2 unsigned byte add", 3'd0, 2'd0, 1'b0, 64'hAAAA_5555_0000_00FF, 64'h0F0F_0000_0000_0001);
        check("R2 literal", out_result, 64'h0);
        run_op("R3 signed half sub", 3'd1, 2'd1, 1'b1, 64'hFFFF_0000_0000_8000, 64'h0000_0001_0000_0001);
        check("R3 literal", out_result, 64'h0000_0000_0000_7FFF);
        // R5: shift amount masked to 3 bits at byte size
        run_op("R5 shl mask", 3'd5, 2'd0, 1'b0, 64'hFF00_0000_0000_0041, 64'd9);
        check("R5 literal", out_result, 64'h82);
        // R6: arithmetic shift of sized operand
        run_op("R6 sar byte", 3'd6, 2'd0, 1'b1, 64'h0000_1111_0000_0080, 64'd1);
        check("R6 literal", out_result, 64'hFFFF_FFFF_FFFF_FFC0);
        run_op("R6 shr word", 3'd6, 2'd2, 1'b0, 64'hFFFF_FFFF_8000_0000, 64'd31);
        check("R6 literal lsr", out_result, 64'h1);
        // R7 / R8: compare ignores upper garbage
        run_op("R7 signed cmp", 3'd7, 2'd0, 1'b1, 64'h7FFF_FFFF_FFFF_FF80, 64'h0000_0000_0000_0001);
        check("R7 literal lt", out_result, 64'd2);
        run_op("R7 unsigned cmp", 3'd7, 2'd0, 1'b0, 64'h0000_0000_0000_0080, 64'hFFFF_FFFF_FFFF_FF01);
        check("R7 literal gt", out_result, 64'd4);
        run_op("R8 cmp eq garbage", 3'd7, 2'd1, 1'b1, 64'h1234_5678_9ABC_BEEF, 64'h0000_0000_0000_BEEF);
        check("R8 literal eq", out_result, 64'd1);
        run_op("R4 xor word", 3'd4, 2'd2, 1'b1, 64'h1111_1111_F0F0_F0F0, 64'h2222_2222_0F0F_0F0F);
        check("R4 literal", out_result, 64'hFFFF_FFFF_FFFF_FFFF);

        // R9: idle cycle holds result and drops valid
        held = out_result;
        in_valid = 1'b0; in_a = 64'h5; in_b = 64'h6;
        @(negedge clk);
        check("R9 idle valid", {63'd0, out_valid}, 64'd0);
        check("R9 idle hold", out_result, held);

        // Random: all ops, sizes and signednesses, full 64-bit garbage
        for (int i = 0; i < 3000; i++) begin
            logic [63:0] ra, rb;
            logic [2:0]  op;
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            op = 3'($urandom_range(0, 7));
            if (i % 4 == 0) rb = ra ^ (64'hFFFF_0000_0000_0000 & {$urandom, $urandom});
            run_op(op_tag(op), op, 2'(i % 4), 1'((i / 4) % 2), ra, rb);
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule